// File: doc/BRIEF.md
# Dual-Granularity Synchronizing FIFO

This block is a dedicated point-to-point channel between one producer stage and one consumer stage. The two stages agree on tokens at different sizes: a row of 8 tokens and a block of 64 tokens. The channel holds up to 256 tokens in an internal array. Before it writes, the producer must reserve free room through a check request. Before it reads, the consumer must reserve committed data through its own check request. Each side then hands its work over with a signal pulse: signal-data publishes written tokens to the consumer, and signal-room returns read slots to the producer.

Each side checks and signals at its own granularity, so the block keeps four counts of its own. Two are global: free room and committed data. Two are per side: reserved credit and written-but-unpublished (or read-but-unreleased) tokens. These counts are separate from the storage pointers. The defaults match a block-oriented producer (checks a block, publishes rows) feeding a row-oriented consumer (checks a row, releases blocks). Four static parameters choose row or block for each check and each signal.

Each check port has a three-state sequencer:
- IDLE moves to WAIT when a request is sampled.
- WAIT moves to GRANT once the available count covers the outstanding reservation plus one check unit. The reservation is taken on that edge.
- GRANT drives the grant output for one cycle and always returns to IDLE.

While the sequencer is in WAIT or GRANT, a request input is ignored.

Top module: `dual_gran_fifo`

## Requirements
- R1: After reset both grants are low, write-ready and read-valid are low, both error flags are low, free room is 256 and committed data is 0.
- R2: A producer request sampled in IDLE moves to WAIT. The grant rises one cycle after the free count reaches the producer's outstanding reservation plus its check unit (64 tokens by default) while in WAIT. The grant lasts exactly one cycle.
- R3: Write-ready is high exactly while the producer holds reserved credit. Each accepted write uses one credit and one free slot.
- R4: Written tokens are invisible to the consumer until signal-data. A signal-data pulse publishes one producer signal unit (8 tokens by default) to the committed count.
- R5: A consumer request is granted by the same three-state sequence. The condition is that committed data covers the consumer's outstanding reservation plus its check unit (8 tokens by default).
- R6: Read-valid is high exactly while the consumer holds reserved credit. Read data presents tokens in the order they were written.
- R7: Read slots become free only on signal-room. Each pulse frees one consumer signal unit (64 tokens by default). A producer check stalls in WAIT until that room exists.
- R8: A signal-data pulse is ignored, and sets a sticky producer error flag, if fewer than one signal unit is pending (the count is taken before any write in the same cycle). A signal-room pulse is ignored, and sets a sticky consumer error flag, if fewer than one signal unit has been read and not released. Only reset clears either flag.
- R9: Read and write pointers wrap modulo 256, and order is kept across the wrap.
- R10: A write and a read in the same cycle are both accepted.
- R11: The check and signal units of each side are static parameters, each row (8) or block (64). The defaults are: producer checks block and signals row; consumer checks row and signals block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| prd_chk_req | input | 1 | Producer room check request |
| prd_chk_gnt | output | 1 | One-cycle room grant |
| prd_wr_valid | input | 1 | Producer write strobe |
| prd_wr_ready | output | 1 | Producer holds room credit |
| prd_wr_data | input | DATA_W | Write token |
| prd_sig_data | input | 1 | Publish one producer signal unit |
| prd_err | output | 1 | Sticky over-publish flag |
| cns_chk_req | input | 1 | Consumer data check request |
| cns_chk_gnt | output | 1 | One-cycle data grant |
| cns_rd_valid | output | 1 | Consumer holds data credit |
| cns_rd_ready | input | 1 | Consumer read strobe |
| cns_rd_data | output | DATA_W | Token at the read pointer |
| cns_sig_room | input | 1 | Release one consumer signal unit |
| cns_err | output | 1 | Sticky over-release flag |

## Verification
The hardest state to reach from the ports is a producer check stalled in WAIT because the array is full, while the consumer still holds a row that it has read but cannot yet release. To reach it, the bench has the consumer take one early row. It then stays idle while the producer fills all four blocks and requests a fifth. The consumer then resumes, reads 56 more tokens, and releases a block, which unblocks the producer while both sides run in the same cycles across the pointer wrap.

// File: rtl/dgf_pkg.sv
package dgf_pkg;

    typedef enum logic {
        GR_ROW   = 1'b0,
        GR_BLOCK = 1'b1
    } gran_e;

    typedef enum logic [1:0] {
        CK_IDLE  = 2'd0,
        CK_WAIT  = 2'd1,
        CK_GRANT = 2'd2
    } ck_state_e;

    function automatic int unit_tokens(gran_e g, int row_tok, int blk_tok);
        return (g == GR_ROW) ? row_tok : blk_tok;
    endfunction

endpackage

// File: rtl/dgf_check_fsm.sv
module dgf_check_fsm
    import dgf_pkg::*;
#(
    parameter int CNT_W  = 9,
    parameter int TOKENS = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic [CNT_W-1:0] avail,
    input  logic             take,
    output logic             gnt,
    output logic             has_credit
);

    localparam logic [CNT_W:0] TOK_X = (CNT_W+1)'(TOKENS);

    ck_state_e        state_q, state_d;
    logic [CNT_W-1:0] resv_q;
    logic             fits;
    logic             grant_ev;

    assign fits     = {1'b0, avail} >= ({1'b0, resv_q} + TOK_X);
    assign grant_ev = (state_q == CK_WAIT) && fits;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CK_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CK_IDLE:  state_d = req ? CK_WAIT : CK_IDLE;
            CK_WAIT:  state_d = fits ? CK_GRANT : CK_WAIT;
            CK_GRANT: state_d = CK_IDLE;
            default:  state_d = CK_IDLE;
        endcase
    end

    always_comb begin
        gnt        = (state_q == CK_GRANT);
        has_credit = (resv_q != '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            resv_q <= '0;
        end else begin
            resv_q <= resv_q + (grant_ev ? TOK_X[CNT_W-1:0] : '0)
                              - CNT_W'(take && has_credit);
        end
    end

    // R2 / R5: grant is a single-cycle pulse
    a_r2_gnt_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        gnt |=> !gnt);

    // R2 / R5: reserved credit never exceeds what is available
    a_r5_resv_within_avail: assert property (@(posedge clk) disable iff (!rst_n)
        resv_q <= avail);

endmodule

// File: rtl/dgf_release_acct.sv
module dgf_release_acct #(
    parameter int CNT_W  = 9,
    parameter int TOKENS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic take,
    input  logic sig,
    output logic commit,
    output logic err
);

    localparam logic [CNT_W-1:0] TOK_W = CNT_W'(TOKENS);

    logic [CNT_W-1:0] pend_q;
    logic             err_q;

    assign commit = sig && (pend_q >= TOK_W);
    assign err    = err_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
            err_q  <= 1'b0;
        end else begin
            pend_q <= pend_q + CNT_W'(take) - (commit ? TOK_W : '0);
            if (sig && !commit) begin
                err_q <= 1'b1;
            end
        end
    end

    // R8: error flag never clears once set
    a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);

    // R8: an under-covered signal pulse always raises the flag
    a_r8_short_signal_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (sig && (pend_q < TOK_W)) |=> err);

endmodule

// File: rtl/dgf_store.sv
module dgf_store #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wptr_q, rptr_q;

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wptr_q] <= wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr_q <= '0;
            rptr_q <= '0;
        end else begin
            if (wr_en) begin
                wptr_q <= (wptr_q == LAST) ? '0 : wptr_q + 1'b1;
            end
            if (rd_en) begin
                rptr_q <= (rptr_q == LAST) ? '0 : rptr_q + 1'b1;
            end
        end
    end

    assign rd_data = mem[rptr_q];

    // R10: a free slot and a committed slot never coincide
    a_r10_slots_distinct: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && rd_en) |-> (wptr_q != rptr_q));

endmodule

// File: rtl/dual_gran_fifo.sv
module dual_gran_fifo
    import dgf_pkg::*;
#(
    parameter int    DATA_W     = 16,
    parameter int    DEPTH      = 256,
    parameter int    ROW_TOK    = 8,
    parameter int    BLOCK_TOK  = 64,
    parameter gran_e PRD_CHECK  = GR_BLOCK,
    parameter gran_e PRD_SIGNAL = GR_ROW,
    parameter gran_e CNS_CHECK  = GR_ROW,
    parameter gran_e CNS_SIGNAL = GR_BLOCK
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prd_chk_req,
    output logic              prd_chk_gnt,
    input  logic              prd_wr_valid,
    output logic              prd_wr_ready,
    input  logic [DATA_W-1:0] prd_wr_data,
    input  logic              prd_sig_data,
    output logic              prd_err,
    input  logic              cns_chk_req,
    output logic              cns_chk_gnt,
    output logic              cns_rd_valid,
    input  logic              cns_rd_ready,
    output logic [DATA_W-1:0] cns_rd_data,
    input  logic              cns_sig_room,
    output logic              cns_err
);

    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int P_CHK = unit_tokens(PRD_CHECK,  ROW_TOK, BLOCK_TOK);
    localparam int P_SIG = unit_tokens(PRD_SIGNAL, ROW_TOK, BLOCK_TOK);
    localparam int C_CHK = unit_tokens(CNS_CHECK,  ROW_TOK, BLOCK_TOK);
    localparam int C_SIG = unit_tokens(CNS_SIGNAL, ROW_TOK, BLOCK_TOK);
    localparam logic [CNT_W-1:0] P_SIG_W = CNT_W'(P_SIG);
    localparam logic [CNT_W-1:0] C_SIG_W = CNT_W'(C_SIG);
    localparam logic [CNT_W:0]   DEPTH_X = (CNT_W+1)'(DEPTH);

    logic [CNT_W-1:0] free_cnt, data_cnt;
    logic             wr_fire, rd_fire;
    logic             data_commit, room_commit;

    assign wr_fire = prd_wr_valid && prd_wr_ready;
    assign rd_fire = cns_rd_ready && cns_rd_valid;

    dgf_check_fsm #(.CNT_W(CNT_W), .TOKENS(P_CHK)) u_prd_chk (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (prd_chk_req),
        .avail      (free_cnt),
        .take       (prd_wr_valid),
        .gnt        (prd_chk_gnt),
        .has_credit (prd_wr_ready)
    );

    dgf_check_fsm #(.CNT_W(CNT_W), .TOKENS(C_CHK)) u_cns_chk (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (cns_chk_req),
        .avail      (data_cnt),
        .take       (cns_rd_ready),
        .gnt        (cns_chk_gnt),
        .has_credit (cns_rd_valid)
    );

    dgf_release_acct #(.CNT_W(CNT_W), .TOKENS(P_SIG)) u_prd_pub (
        .clk    (clk),
        .rst_n  (rst_n),
        .take   (wr_fire),
        .sig    (prd_sig_data),
        .commit (data_commit),
        .err    (prd_err)
    );

    dgf_release_acct #(.CNT_W(CNT_W), .TOKENS(C_SIG)) u_cns_rel (
        .clk    (clk),
        .rst_n  (rst_n),
        .take   (rd_fire),
        .sig    (cns_sig_room),
        .commit (room_commit),
        .err    (cns_err)
    );

    dgf_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_fire),
        .wr_data (prd_wr_data),
        .rd_en   (rd_fire),
        .rd_data (cns_rd_data)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            free_cnt <= CNT_W'(DEPTH);
            data_cnt <= '0;
        end else begin
            free_cnt <= free_cnt + (room_commit ? C_SIG_W : '0) - CNT_W'(wr_fire);
            data_cnt <= data_cnt + (data_commit ? P_SIG_W : '0) - CNT_W'(rd_fire);
        end
    end

    // R7: free room and committed data together never exceed capacity
    a_r7_capacity: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, free_cnt} + {1'b0, data_cnt}) <= DEPTH_X);

    // R6: read credit implies committed data is present
    a_r6_valid_has_data: assert property (@(posedge clk) disable iff (!rst_n)
        cns_rd_valid |-> (data_cnt != '0));

    // R3: write credit implies a free slot exists
    a_r3_ready_has_room: assert property (@(posedge clk) disable iff (!rst_n)
        prd_wr_ready |-> (free_cnt != '0));

    // R4: a write never immediately raises the committed count by itself
    a_r4_no_silent_publish: assert property (@(posedge clk) disable iff (!rst_n)
        (!data_commit) |=> (data_cnt <= $past(data_cnt)));

endmodule

// File: tb/sim_dual_gran_fifo.sv
module sim_dual_gran_fifo;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        prd_chk_req = 1'b0, prd_wr_valid = 1'b0, prd_sig_data = 1'b0;
    logic [15:0] prd_wr_data = '0;
    logic        cns_chk_req = 1'b0, cns_rd_ready = 1'b0, cns_sig_room = 1'b0;
    logic        prd_chk_gnt, prd_wr_ready, prd_err;
    logic        cns_chk_gnt, cns_rd_valid, cns_err;
    logic [15:0] cns_rd_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    dual_gran_fifo u0 (
        .clk(clk), .rst_n(rst_n),
        .prd_chk_req(prd_chk_req), .prd_chk_gnt(prd_chk_gnt),
        .prd_wr_valid(prd_wr_valid), .prd_wr_ready(prd_wr_ready),
        .prd_wr_data(prd_wr_data), .prd_sig_data(prd_sig_data), .prd_err(prd_err),
        .cns_chk_req(cns_chk_req), .cns_chk_gnt(cns_chk_gnt),
        .cns_rd_valid(cns_rd_valid), .cns_rd_ready(cns_rd_ready),
        .cns_rd_data(cns_rd_data), .cns_sig_room(cns_sig_room), .cns_err(cns_err)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference model
    int m_free, m_data, m_presv, m_cresv, m_wpend, m_rpend, m_pph, m_cph;
    bit m_perr, m_cerr;
    logic [15:0] m_q[$];
    int both_fire = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_free = 256; m_data = 0; m_presv = 0; m_cresv = 0;
            m_wpend = 0; m_rpend = 0; m_pph = 0; m_cph = 0;
            m_perr = 0; m_cerr = 0; m_q.delete();
        end else begin
            bit wf, rf, pg, cg, pc, cc;
            wf = prd_wr_valid && (m_presv > 0);
            rf = cns_rd_ready && (m_cresv > 0);
            pg = (m_pph == 1) && (m_free >= m_presv + 64);
            cg = (m_cph == 1) && (m_data >= m_cresv + 8);
            pc = prd_sig_data && (m_wpend >= 8);
            cc = cns_sig_room && (m_rpend >= 64);
            if (wf && rf) both_fire++;
            if (prd_sig_data && !pc) m_perr = 1;
            if (cns_sig_room && !cc) m_cerr = 1;
            m_pph = (m_pph == 0) ? (prd_chk_req ? 1 : 0) : (m_pph == 1) ? (pg ? 2 : 1) : 0;
            m_cph = (m_cph == 0) ? (cns_chk_req ? 1 : 0) : (m_cph == 1) ? (cg ? 2 : 1) : 0;
            m_presv += (pg ? 64 : 0) - int'(wf);
            m_free  += (cc ? 64 : 0) - int'(wf);
            m_wpend += int'(wf) - (pc ? 8 : 0);
            m_data  += (pc ? 8 : 0) - int'(rf);
            m_cresv += (cg ? 8 : 0) - int'(rf);
            m_rpend += int'(rf) - (cc ? 64 : 0);
            if (rf) void'(m_q.pop_front());
            if (wf) m_q.push_back(prd_wr_data);
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(prd_chk_gnt == (m_pph == 2), "R2 producer grant", prd_chk_gnt, m_pph == 2);
            check(cns_chk_gnt == (m_cph == 2), "R5 R11 consumer grant", cns_chk_gnt, m_cph == 2);
            check(prd_wr_ready == (m_presv > 0), "R3 write ready", prd_wr_ready, m_presv > 0);
            check(cns_rd_valid == (m_cresv > 0), "R6 read valid", cns_rd_valid, m_cresv > 0);
            if (m_cresv > 0 && m_q.size() > 0)
                check(cns_rd_data == m_q[0], "R6 R9 read order", cns_rd_data, m_q[0]);
            check(prd_err == m_perr, "R8 producer error", prd_err, m_perr);
            check(cns_err == m_cerr, "R8 consumer error", cns_err, m_cerr);
        end
    end

    int prd_stall5 = 0;
    int cns_first_wait = 0;
    int reads_done = 0;

    task automatic produce(input int blocks);
        int seq = 0;
        for (int b = 0; b < blocks; b++) begin
            int w = 0;
            prd_chk_req = 1; @(negedge clk); prd_chk_req = 0;
            while (!prd_chk_gnt) begin
                @(negedge clk);
                w++;
            end
            if (b == 4) prd_stall5 = w;
            for (int i = 0; i < 64; i++) begin
                prd_wr_valid = 1;
                prd_wr_data  = 16'(seq * 37 + 5);
                prd_sig_data = (i != 0) && (i % 8 == 0);
                seq++;
                @(negedge clk);
            end
            prd_wr_valid = 0;
            prd_sig_data = 1; @(negedge clk); prd_sig_data = 0;
        end
    endtask

    task automatic consume_row(output int waited);
        waited = 0;
        cns_chk_req = 1; @(negedge clk); cns_chk_req = 0;
        while (!cns_chk_gnt) begin
            @(negedge clk);
            waited++;
        end
        for (int j = 0; j < 8; j++) begin
            if ((reads_done % 5) == 3) begin
                cns_rd_ready = 0; @(negedge clk);
            end
            cns_rd_ready = 1; @(negedge clk);
            reads_done++;
        end
        cns_rd_ready = 0;
        if (reads_done % 64 == 0) begin
            cns_sig_room = 1; @(negedge clk); cns_sig_room = 0;
        end
    endtask

    task automatic consume(input int rows);
        int wt;
        consume_row(cns_first_wait);
        repeat (400) @(negedge clk);
        for (int r = 1; r < rows; r++) consume_row(wt);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=0 expected=1");
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int w;
        repeat (4) @(negedge clk);
        // R1: reset state
        check(prd_chk_gnt == 0, "R1 reset producer grant", prd_chk_gnt, 0);
        check(cns_chk_gnt == 0, "R1 reset consumer grant", cns_chk_gnt, 0);
        check(prd_wr_ready == 0, "R1 reset write ready", prd_wr_ready, 0);
        check(cns_rd_valid == 0, "R1 reset read valid", cns_rd_valid, 0);
        check(prd_err == 0 && cns_err == 0, "R1 reset errors", prd_err | cns_err, 0);
        rst_n = 1;
        @(negedge clk);

        fork
            produce(6);
            consume(48);
        join

        // R4 R11: first row granted only after first publish, well before a block
        check(cns_first_wait >= 10, "R4 data hidden before publish", cns_first_wait, 10);
        check(cns_first_wait < 30, "R11 row-granular consumer check", cns_first_wait, 30);
        // R7: fifth block waited for released room
        check(prd_stall5 > 100, "R7 producer stalled on full", prd_stall5, 101);
        // R9: data passed through more than capacity
        check(reads_done == 384, "R9 wrap token count", reads_done, 384);
        // R10: concurrent transfers seen
        check(both_fire > 0, "R10 simultaneous read write", both_fire, 1);

        // R8: over-signal on both sides
        repeat (3) @(negedge clk);
        prd_sig_data = 1; cns_sig_room = 1; @(negedge clk);
        prd_sig_data = 0; cns_sig_room = 0;
        repeat (2) @(negedge clk);
        check(prd_err == 1, "R8 producer flag set", prd_err, 1);
        check(cns_err == 1, "R8 consumer flag set", cns_err, 1);
        // R8: ignored publish adds no data: consumer check must not grant
        w = 0;
        cns_chk_req = 1; @(negedge clk); cns_chk_req = 0;
        repeat (20) begin
            if (cns_chk_gnt) w++;
            @(negedge clk);
        end
        check(w == 0, "R8 ignored publish leaves no data", w, 0);
        check(prd_err == 1 && cns_err == 1, "R8 flags sticky", prd_err & cns_err, 1);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule